// File: doc/BRIEF.md
# Graphics Packet Tag Unpacker

This block takes a stream of 128-bit quadwords and turns it into single register writes. A stream is made of groups. Each group opens with a header quadword (the tag). The tag names a loop count, a count of descriptors and up to sixteen 4-bit descriptors. The block then walks those descriptors in a ring, one per data item, once for each loop. Every data item becomes a write of an 8-bit register address and a 64-bit value on a valid/ready write port. When the header has its preset bit set, it also supplies a primitive value. That value is written before any payload is taken.

Three payload modes exist. In packed mode each item uses a full quadword, and its fields are repacked according to the descriptor. In list mode each quadword carries two raw 64-bit items, low half first. In image mode the quadwords are not interpreted at all and go out on a separate port. A flag marks the last write or last image quadword of a group whose header asks for an end-of-packet marker. Another flag reports when the current header lists only one descriptor and that descriptor is the address-plus-data kind.

Top module: `pkt_tag_unpack`

## Requirements
- R1: After reset the block waits for a header: `in_ready` is 1, `wr_valid` and `img_valid` are 0, and `ad_only` is 0.
- R2: Header fields are taken from fixed bit positions: loop count [14:0], end marker [15], preset [46], primitive [57:47], mode [59:58], descriptor count [63:60], and descriptor i at [67+4i:64+4i]. In packed mode, descriptor 0 writes address 0x00 with data [10:0]. Descriptor 1 writes 0x01 with the bytes at [7:0], [39:32], [71:64] and [103:96] placed as data bytes 0 to 3. Descriptor 2 writes 0x02 with [63:0]. Descriptor 3 writes 0x03 with [13:0] in data [13:0] and [45:32] in data [29:16]. Descriptor 0xA writes 0x0A with [107:100] in data [63:56]. Codes 6–9, 0xB, 0xC and 0xD write [63:0] to the address equal to the code.
- R3: In packed mode, descriptor 4 writes data {[107:100],[91:68],[47:32],[15:0]}. Descriptor 5 writes data {[95:64],[47:32],[15:0]}. If bit 111 is set, the address is 0x0C (for 4) or 0x0D (for 5); otherwise it is 0x04 or 0x05.
- R4: After each item the descriptor index advances. When the index reaches the descriptor count it wraps to 0 and the loop count drops by one. The index arithmetic is modulo 16, so a count of 0 uses all sixteen descriptors. The quadword after the last item is read as a new header.
- R5: Descriptor 0xE in packed mode writes data [63:0] to the address held in [71:64]. `ad_only` is 1 while the current header has a count of 1 and descriptor 0 equal to 0xE.
- R6: Descriptor 0xF in packed mode takes the quadword and makes no write.
- R7: Mode 1 (list) takes two items per quadword, [63:0] first, then [127:64]. Each item writes its raw 64 bits to the address equal to its descriptor code. Codes 0xE and 0xF make no write. If the total item count is odd, the high half of the last quadword is dropped.
- R8: Mode 2 or 3 (image) passes the loop count's number of quadwords unchanged to `img_data`, under `img_valid`/`img_ready`, with no write.
- R9: A header with the preset bit set makes one write to address 0x00 with its primitive field, with `wr_preset` high. This write comes before any payload quadword is accepted.
- R10: A header with loop count 0 takes no payload. The next quadword is a header.
- R11: If the header's end bit is set, `wr_last` (or `img_last`) is high on the write of the group's final item. If the group has no items, it is high on the preset write instead.
- R12: While a write is offered and `wr_ready` is 0, no quadword is accepted and the write holds its address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input quadword valid |
| in_ready | output | 1 | Input quadword accepted when high with `in_valid` |
| in_data | input | 128 | Input quadword |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Register write taken |
| wr_addr | output | 8 | Register address |
| wr_data | output | 64 | Register data |
| wr_last | output | 1 | Write is the final one of a marked group |
| wr_preset | output | 1 | Write is the header's primitive preset |
| img_valid | output | 1 | Image quadword offered |
| img_ready | input | 1 | Image quadword taken |
| img_data | output | 128 | Image quadword |
| img_last | output | 1 | Image quadword is the final one of a marked group |
| ad_only | output | 1 | Current header has only one descriptor, of the address-plus-data kind |

## Verification
The end-of-packet marking and the return to header parsing fall in the same cycle. The final item's write carries `wr_last`, and that same accepted quadword moves the walker back to expecting a header. The stimulus puts the next header directly behind the final payload quadword, with no idle cycle, and also after a list group whose high half is dropped. The check is that the marked write has the right address and data, and that the quadword right after it is parsed as a header (its own writes appear with the correct addresses). The same collision arises between a preset write and an empty group: this case must carry the end marker on the preset write and then re-arm at once.

// File: rtl/pkt_pkg.sv
`timescale 1ns/1ps
package pkt_pkg;

  localparam int QW_W    = 128;
  localparam int DATA_W  = 64;
  localparam int ADDR_W  = 8;
  localparam int DESC_W  = 4;
  localparam int NDESC   = 16;
  localparam int LOOP_W  = 15;
  localparam int PRIM_W  = 11;
  localparam int IDX_W   = $clog2(NDESC);

  // header bit positions
  localparam int HB_END    = 15;
  localparam int HB_PRE    = 46;
  localparam int HB_PRIM   = 47;
  localparam int HB_MODE   = 58;
  localparam int HB_COUNT  = 60;
  localparam int HB_DESC   = 64;

  // descriptor codes
  localparam logic [DESC_W-1:0] DC_PRIM  = 4'h0;
  localparam logic [DESC_W-1:0] DC_COLOR = 4'h1;
  localparam logic [DESC_W-1:0] DC_TEXST = 4'h2;
  localparam logic [DESC_W-1:0] DC_TEXUV = 4'h3;
  localparam logic [DESC_W-1:0] DC_POSF  = 4'h4;
  localparam logic [DESC_W-1:0] DC_POS   = 4'h5;
  localparam logic [DESC_W-1:0] DC_FOG   = 4'hA;
  localparam logic [DESC_W-1:0] DC_ADDR  = 4'hE;
  localparam logic [DESC_W-1:0] DC_SKIP  = 4'hF;

  localparam logic [ADDR_W-1:0] RA_PRIM  = 8'h00;
  localparam logic [ADDR_W-1:0] RA_POSF_K = 8'h0C;
  localparam logic [ADDR_W-1:0] RA_POS_K  = 8'h0D;

  typedef enum logic [2:0] {
    ST_HDR, ST_PRESET, ST_PACKED, ST_LIST, ST_IMAGE
  } walk_state_e;

  typedef struct packed {
    logic [NDESC*DESC_W-1:0] descs;
    logic [DESC_W-1:0]       count;
    logic [1:0]              mode;
    logic [PRIM_W-1:0]       prim;
    logic                    pre;
    logic                    last_mark;
    logic [LOOP_W-1:0]       loops;
  } hdr_t;

  function automatic walk_state_e payload_state(input logic [1:0] mode);
    case (mode)
      2'd0:    return ST_PACKED;
      2'd1:    return ST_LIST;
      default: return ST_IMAGE;
    endcase
  endfunction

endpackage

// File: rtl/pkt_hdr_fields.sv
`timescale 1ns/1ps
module pkt_hdr_fields
  import pkt_pkg::*;
(
  input  logic [QW_W-1:0] qw,
  output hdr_t            hdr,
  output logic            single_ad
);

  logic [DESC_W-1:0] desc_arr [NDESC];

  generate
    for (genvar g = 0; g < NDESC; g++) begin : g_desc
      assign desc_arr[g] = qw[HB_DESC + g*DESC_W +: DESC_W];
      assign hdr.descs[g*DESC_W +: DESC_W] = desc_arr[g];
    end
  endgenerate

  assign hdr.loops     = qw[LOOP_W-1:0];
  assign hdr.last_mark = qw[HB_END];
  assign hdr.pre       = qw[HB_PRE];
  assign hdr.prim      = qw[HB_PRIM +: PRIM_W];
  assign hdr.mode      = qw[HB_MODE +: 2];
  assign hdr.count     = qw[HB_COUNT +: DESC_W];

  assign single_ad = (hdr.count == 4'd1) && (desc_arr[0] == DC_ADDR);

endmodule

// File: rtl/pkt_item_fmt.sv
`timescale 1ns/1ps
module pkt_item_fmt
  import pkt_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  input  logic [QW_W-1:0]   qw,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              no_write
);

  always_comb begin
    addr     = {{(ADDR_W-DESC_W){1'b0}}, desc};
    data     = qw[DATA_W-1:0];
    no_write = 1'b0;
    case (desc)
      DC_PRIM: begin
        data = {{(DATA_W-PRIM_W){1'b0}}, qw[PRIM_W-1:0]};
      end
      DC_COLOR: begin
        data = {32'd0, qw[103:96], qw[71:64], qw[39:32], qw[7:0]};
      end
      DC_TEXST: begin
        data = qw[63:0];
      end
      DC_TEXUV: begin
        data = {32'd0, 2'b00, qw[45:32], 2'b00, qw[13:0]};
      end
      DC_POSF: begin
        data = {qw[107:100], qw[91:68], qw[47:32], qw[15:0]};
        if (qw[111]) addr = RA_POSF_K;
      end
      DC_POS: begin
        data = {qw[95:64], qw[47:32], qw[15:0]};
        if (qw[111]) addr = RA_POS_K;
      end
      DC_FOG: begin
        data = {qw[107:100], 56'd0};
      end
      DC_ADDR: begin
        addr = qw[64 +: ADDR_W];
        data = qw[63:0];
      end
      DC_SKIP: begin
        no_write = 1'b1;
      end
      default: begin
        data = qw[DATA_W-1:0];
      end
    endcase
  end

endmodule

// File: rtl/pkt_loop_walker.sv
`timescale 1ns/1ps
module pkt_loop_walker #(
  parameter int IDX_W  = 4,
  parameter int LOOP_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IDX_W-1:0]  load_count,
  input  logic [LOOP_W-1:0] load_loops,
  input  logic              step,
  output logic [IDX_W-1:0]  idx,
  output logic [LOOP_W-1:0] loops_left,
  output logic              group_end,
  output logic              last_item
);

  localparam logic [IDX_W-1:0]  IDX_ONE  = {{(IDX_W-1){1'b0}}, 1'b1};
  localparam logic [LOOP_W-1:0] LOOP_ONE = {{(LOOP_W-1){1'b0}}, 1'b1};

  logic [IDX_W-1:0]  idx_q, idx_d, idx_inc, count_q, count_d;
  logic [LOOP_W-1:0] loops_q, loops_d;
  logic              upd_en;

  assign idx_inc    = idx_q + IDX_ONE;
  assign group_end  = (idx_inc == count_q);
  assign last_item  = group_end && (loops_q == LOOP_ONE);
  assign idx        = idx_q;
  assign loops_left = loops_q;
  assign upd_en     = load | step;

  always_comb begin
    idx_d   = idx_q;
    loops_d = loops_q;
    count_d = count_q;
    if (load) begin
      idx_d   = '0;
      loops_d = load_loops;
      count_d = load_count;
    end else if (step) begin
      if (group_end) begin
        idx_d   = '0;
        loops_d = loops_q - LOOP_ONE;
      end else begin
        idx_d = idx_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      loops_q <= '0;
      count_q <= '0;
    end else if (upd_en) begin
      idx_q   <= idx_d;
      loops_q <= loops_d;
      count_q <= count_d;
    end
  end

  AST_IDX_UNDER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != '0) |-> (idx_q < count_q)); // R4

  AST_LOOP_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && group_end) |=> (loops_q == $past(loops_q) - LOOP_ONE)); // R4

endmodule

// File: rtl/pkt_tag_unpack.sv
`timescale 1ns/1ps
module pkt_tag_unpack
  import pkt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [QW_W-1:0]    in_data,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic               wr_last,
  output logic               wr_preset,
  output logic               img_valid,
  input  logic               img_ready,
  output logic [QW_W-1:0]    img_data,
  output logic               img_last,
  output logic               ad_only
);

  localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};

  hdr_t                     hdr_in;
  logic                     single_ad_in;
  walk_state_e              state_q, state_d;
  logic [NDESC*DESC_W-1:0]  descs_q;
  logic [PRIM_W-1:0]        prim_q;
  logic [1:0]               mode_q;
  logic                     mark_q, adonly_q, half_q, half_d;
  logic                     hdr_load, walk_step;
  logic [IDX_W-1:0]         idx, load_count;
  logic [LOOP_W-1:0]        loops_left;
  logic                     group_end, last_item;
  logic [DESC_W-1:0]        cur_desc;
  logic [ADDR_W-1:0]        pk_addr;
  logic [DATA_W-1:0]        pk_data;
  logic                     pk_skip, ls_skip, ls_done;
  logic [DATA_W-1:0]        ls_item;

  pkt_hdr_fields u_fields (
    .qw        (in_data),
    .hdr       (hdr_in),
    .single_ad (single_ad_in)
  );

  assign cur_desc = descs_q[{idx, 2'b00} +: DESC_W];

  pkt_item_fmt u_fmt (
    .desc     (cur_desc),
    .qw       (in_data),
    .addr     (pk_addr),
    .data     (pk_data),
    .no_write (pk_skip)
  );

  assign load_count = hdr_in.mode[1] ? IDX_ONE : hdr_in.count;

  pkt_loop_walker #(
    .IDX_W  (IDX_W),
    .LOOP_W (LOOP_W)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (hdr_load),
    .load_count (load_count),
    .load_loops (hdr_in.loops),
    .step       (walk_step),
    .idx        (idx),
    .loops_left (loops_left),
    .group_end  (group_end),
    .last_item  (last_item)
  );

  assign ls_item  = half_q ? in_data[QW_W-1:DATA_W] : in_data[DATA_W-1:0];
  assign ls_skip  = (cur_desc == DC_ADDR) || (cur_desc == DC_SKIP);
  assign ls_done  = in_valid && (ls_skip || wr_ready);
  assign img_data = in_data;
  assign ad_only  = adonly_q;

  // next state and outputs
  always_comb begin
    state_d   = state_q;
    half_d    = half_q;
    hdr_load  = 1'b0;
    walk_step = 1'b0;
    in_ready  = 1'b0;
    wr_valid  = 1'b0;
    wr_addr   = '0;
    wr_data   = '0;
    wr_last   = 1'b0;
    wr_preset = 1'b0;
    img_valid = 1'b0;
    img_last  = 1'b0;
    case (state_q)
      ST_HDR: begin
        in_ready = 1'b1;
        half_d   = 1'b0;
        if (in_valid) begin
          hdr_load = 1'b1;
          if (hdr_in.pre)
            state_d = ST_PRESET;
          else if (hdr_in.loops == '0)
            state_d = ST_HDR;
          else
            state_d = payload_state(hdr_in.mode);
        end
      end
      ST_PRESET: begin
        wr_valid  = 1'b1;
        wr_preset = 1'b1;
        wr_addr   = RA_PRIM;
        wr_data   = {{(DATA_W-PRIM_W){1'b0}}, prim_q};
        wr_last   = mark_q && (loops_left == '0);
        if (wr_ready)
          state_d = (loops_left == '0) ? ST_HDR : payload_state(mode_q);
      end
      ST_PACKED: begin
        wr_valid = in_valid && !pk_skip;
        wr_addr  = pk_addr;
        wr_data  = pk_data;
        wr_last  = in_valid && !pk_skip && mark_q && last_item;
        in_ready = pk_skip || wr_ready;
        if (in_valid && in_ready) begin
          walk_step = 1'b1;
          if (last_item) state_d = ST_HDR;
        end
      end
      ST_LIST: begin
        wr_valid = in_valid && !ls_skip;
        wr_addr  = {{(ADDR_W-DESC_W){1'b0}}, cur_desc};
        wr_data  = ls_item;
        wr_last  = in_valid && !ls_skip && mark_q && last_item;
        in_ready = (ls_skip || wr_ready) && (half_q || last_item);
        if (ls_done) begin
          walk_step = 1'b1;
          if (last_item) begin
            state_d = ST_HDR;
            half_d  = 1'b0;
          end else begin
            half_d = !half_q;
          end
        end
      end
      ST_IMAGE: begin
        img_valid = in_valid;
        img_last  = in_valid && mark_q && last_item;
        in_ready  = img_ready;
        if (in_valid && img_ready) begin
          walk_step = 1'b1;
          if (last_item) state_d = ST_HDR;
        end
      end
      default: state_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HDR;
      half_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      half_q  <= half_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      descs_q  <= '0;
      prim_q   <= '0;
      mode_q   <= '0;
      mark_q   <= 1'b0;
      adonly_q <= 1'b0;
    end else if (hdr_load) begin
      descs_q  <= hdr_in.descs;
      prim_q   <= hdr_in.prim;
      mode_q   <= hdr_in.mode;
      mark_q   <= hdr_in.last_mark;
      adonly_q <= single_ad_in;
    end
  end

  AST_PRESET_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_preset |-> (!in_ready && wr_addr == RA_PRIM)); // R9

  AST_LAST_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |-> wr_valid); // R11

  AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && img_valid)); // R8

  AST_PAYLOAD_HAS_LOOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_PACKED, ST_LIST, ST_IMAGE}) |-> (loops_left != '0)); // R10

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PACKED && wr_valid && !wr_ready) |-> !in_ready); // R12

  AST_POSF_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PACKED && cur_desc == DC_POSF && in_data[111] && wr_valid)
      |-> (wr_addr == RA_POSF_K)); // R3

  AST_REARM_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_step && last_item) |=> (state_q == ST_HDR)); // R4

endmodule

// File: tb/sim_pkt_tag_unpack.sv
`timescale 1ns/1ps
module sim_pkt_tag_unpack;

  typedef struct packed {
    logic [23:0]  req;
    logic         last;
    logic         pre;
    logic [7:0]   addr;
    logic [63:0]  data;
  } exp_t;

  typedef struct packed {
    logic [23:0]  req;
    logic         last;
    logic [127:0] data;
  } img_exp_t;

  function automatic logic [127:0] mk_hdr(input logic [14:0] loops, input logic mark,
                                          input logic pre, input logic [10:0] prim,
                                          input logic [1:0] mode, input logic [3:0] cnt,
                                          input logic [63:0] descs);
    return {descs, cnt, mode, prim, pre, 30'd0, mark, loops};
  endfunction

  function automatic logic [127:0] mk_posf(input logic [15:0] x, input logic [15:0] y,
                                           input logic [23:0] z, input logic [7:0] f,
                                           input logic k);
    logic [127:0] q;
    q = '0;
    q[15:0] = x; q[47:32] = y; q[91:68] = z; q[107:100] = f; q[111] = k;
    return q;
  endfunction

  function automatic logic [127:0] mk_pos(input logic [15:0] x, input logic [15:0] y,
                                          input logic [31:0] z, input logic k);
    logic [127:0] q;
    q = '0;
    q[15:0] = x; q[47:32] = y; q[95:64] = z; q[111] = k;
    return q;
  endfunction

  localparam int NSTIM = 33;
  localparam logic [127:0] STIM [NSTIM] = '{
    // group A: packed, preset, 2 loops of {color, pos+fog, skip}
    mk_hdr(15'd2, 1'b0, 1'b1, 11'h2A5, 2'd0, 4'd3, 64'h0F41),
    128'hAB000044_CD000033_EF000022_12000011,
    mk_posf(16'h1234, 16'h5678, 24'hABCDEF, 8'h9A, 1'b0),
    128'hDEAD,
    128'h00000001_00000002_00000003_00000004,
    mk_posf(16'h0001, 16'h0002, 24'h000003, 8'h04, 1'b1),
    128'h0,
    // group B: packed, count 0 (all sixteen), end marker
    mk_hdr(15'd1, 1'b1, 1'b0, 11'h0, 2'd0, 4'd0, 64'h0FFF_FFFF_FFFE_A532),
    128'h11111111_22222222_3F800000_40000000,
    128'h00000000_00000000_FFFF0123_FFFF3ABC,
    mk_pos(16'hAAAA, 16'hBBBB, 32'hCCCCDDDD, 1'b0),
    {20'h0, 8'h5C, 100'h0},
    {56'h0, 8'h42, 64'h0123_4567_89AB_CDEF},
    128'h0, 128'h0, 128'h0, 128'h0, 128'h0,
    128'h0, 128'h0, 128'h0, 128'h0, 128'h0,
    128'h0000_0000_0000_0000_0000_0000_FFFF_F7FF,
    // group C: list, 3 items of code 6
    mk_hdr(15'd3, 1'b0, 1'b0, 11'h0, 2'd1, 4'd1, 64'h6),
    {64'hBBBB_BBBB_BBBB_BBBB, 64'hAAAA_AAAA_AAAA_AAAA},
    {64'hDEAD_DEAD_DEAD_DEAD, 64'hCCCC_CCCC_CCCC_CCCC},
    // group D: list, codes 8, E, 9, end marker
    mk_hdr(15'd1, 1'b1, 1'b0, 11'h0, 2'd1, 4'd3, 64'h9E8),
    {64'h1111_1111_1111_1111, 64'h0808_0808_0808_0808},
    {64'h7777_7777_7777_7777, 64'h0909_0909_0909_0909},
    // group E: empty; group F follows at once
    mk_hdr(15'd0, 1'b0, 1'b0, 11'h0, 2'd0, 4'd1, 64'h1),
    mk_hdr(15'd1, 1'b0, 1'b0, 11'h0, 2'd0, 4'd1, 64'h1),
    128'h00000055_00000066_00000077_00000088
  };

  localparam int NEXP = 17;
  localparam exp_t EXPV [NEXP] = '{
    '{"R9 ", 1'b0, 1'b1, 8'h00, 64'h0000_0000_0000_02A5},
    '{"R2 ", 1'b0, 1'b0, 8'h01, 64'h0000_0000_4433_2211},
    '{"R3 ", 1'b0, 1'b0, 8'h04, 64'h9AAB_CDEF_5678_1234},
    '{"R6 ", 1'b0, 1'b0, 8'h01, 64'h0000_0000_0102_0304},
    '{"R3 ", 1'b0, 1'b0, 8'h0C, 64'h0400_0003_0002_0001},
    '{"R2 ", 1'b0, 1'b0, 8'h02, 64'h3F80_0000_4000_0000},
    '{"R2 ", 1'b0, 1'b0, 8'h03, 64'h0000_0000_0123_3ABC},
    '{"R3 ", 1'b0, 1'b0, 8'h05, 64'hCCCC_DDDD_BBBB_AAAA},
    '{"R2 ", 1'b0, 1'b0, 8'h0A, 64'h5C00_0000_0000_0000},
    '{"R5 ", 1'b0, 1'b0, 8'h42, 64'h0123_4567_89AB_CDEF},
    '{"R4 ", 1'b1, 1'b0, 8'h00, 64'h0000_0000_0000_07FF},
    '{"R7 ", 1'b0, 1'b0, 8'h06, 64'hAAAA_AAAA_AAAA_AAAA},
    '{"R7 ", 1'b0, 1'b0, 8'h06, 64'hBBBB_BBBB_BBBB_BBBB},
    '{"R7 ", 1'b0, 1'b0, 8'h06, 64'hCCCC_CCCC_CCCC_CCCC},
    '{"R7 ", 1'b0, 1'b0, 8'h08, 64'h0808_0808_0808_0808},
    '{"R11", 1'b1, 1'b0, 8'h09, 64'h0909_0909_0909_0909},
    '{"R10", 1'b0, 1'b0, 8'h01, 64'h0000_0000_5566_7788}
  };

  logic         clk, rst_n;
  logic         in_valid, in_ready, wr_valid, wr_ready, wr_last, wr_preset;
  logic         img_valid, img_ready, img_last, ad_only;
  logic [127:0] in_data, img_data;
  logic [7:0]   wr_addr;
  logic [63:0]  wr_data;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [127:0] sq [$];
  exp_t         eq [$];
  img_exp_t     iq [$];

  pkt_tag_unpack u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_last(wr_last), .wr_preset(wr_preset),
    .img_valid(img_valid), .img_ready(img_ready), .img_data(img_data), .img_last(img_last),
    .ad_only(ad_only)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic run_stream(input bit stall);
    int p = 0, e = 0, k = 0, cyc = 0, idle = 0;
    while ((p < sq.size() || idle < 4) && cyc < 5000) begin
      @(negedge clk);
      in_valid  = (p < sq.size());
      in_data   = in_valid ? sq[p] : '0;
      wr_ready  = !stall || (cyc % 3 != 1);
      img_ready = !stall || (cyc % 4 != 2);
      #1;
      if (wr_valid && wr_ready) begin
        if (e < eq.size())
          check($sformatf("%s", eq[e].req), $sformatf("write %0d", e),
                {54'd0, wr_last, wr_preset, wr_addr, wr_data},
                {54'd0, eq[e].last, eq[e].pre, eq[e].addr, eq[e].data});
        else
          check("R6", "unexpected write", {56'd0, wr_addr, wr_data}, '0);
        e++;
      end
      if (img_valid && img_ready) begin
        if (k < iq.size()) begin
          check($sformatf("%s", iq[k].req), $sformatf("image %0d", k), img_data, iq[k].data);
          check($sformatf("%s", iq[k].req), "image last", {127'd0, img_last}, {127'd0, iq[k].last});
        end else
          check("R8", "unexpected image", img_data, '0);
        k++;
      end
      if (in_valid && in_ready) p++;
      if (p >= sq.size()) idle++;
      cyc++;
    end
    check("R4", "writes seen", 128'(e), 128'(eq.size()));
    check("R8", "images seen", 128'(k), 128'(iq.size()));
    check("R4", "quadwords taken", 128'(p), 128'(sq.size()));
    in_valid = 1'b0;
    sq.delete(); eq.delete(); iq.delete();
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 100000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; wr_ready = 1'b1; img_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check("R1", "in_ready", {127'd0, in_ready}, 128'd1);
    check("R1", "wr_valid", {127'd0, wr_valid}, 128'd0);
    check("R1", "img_valid", {127'd0, img_valid}, 128'd0);
    check("R1", "ad_only", {127'd0, ad_only}, 128'd0);

    // vector table walk with back-pressure (R2..R7, R9..R12)
    for (int i = 0; i < NSTIM; i++) sq.push_back(STIM[i]);
    for (int i = 0; i < NEXP; i++) eq.push_back(EXPV[i]);
    run_stream(1'b1);

    // R12 stall and R5 single address-plus-data flag
    @(negedge clk);
    in_valid = 1'b1; wr_ready = 1'b0;
    in_data = mk_hdr(15'd1, 1'b1, 1'b0, 11'h0, 2'd0, 4'd1, 64'hE);
    #1 check("R1", "header taken while write blocked", {127'd0, in_ready}, 128'd1);
    @(negedge clk);
    in_data = {56'h0, 8'h77, 64'hFEED_FACE_0BAD_F00D};
    #1;
    check("R5", "ad_only", {127'd0, ad_only}, 128'd1);
    for (int s = 0; s < 3; s++) begin
      if (s > 0) begin @(negedge clk); #1; end
      check("R12", "in_ready under stall", {127'd0, in_ready}, 128'd0);
      check("R12", "held write", {55'd0, wr_valid, wr_addr, wr_data},
            {55'd0, 1'b1, 8'h77, 64'hFEED_FACE_0BAD_F00D});
    end
    @(negedge clk);
    wr_ready = 1'b1;
    #1 check("R11", "released write", {55'd0, wr_last, wr_addr, wr_data},
             {55'd0, 1'b1, 8'h77, 64'hFEED_FACE_0BAD_F00D});
    @(negedge clk);
    in_valid = 1'b0;
    #1 check("R10", "back at header", {126'd0, in_ready, wr_valid}, 128'd2);

    // R8 image modes 2 and 3
    sq.push_back(mk_hdr(15'd2, 1'b1, 1'b0, 11'h0, 2'd2, 4'd5, 64'h5));
    sq.push_back(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    sq.push_back(128'hFFFF_0000_FFFF_0000_1111_2222_3333_4444);
    sq.push_back(mk_hdr(15'd1, 1'b0, 1'b0, 11'h0, 2'd3, 4'd0, 64'h0));
    sq.push_back(128'h5A5A_5A5A_5A5A_5A5A_A5A5_A5A5_A5A5_A5A5);
    iq.push_back('{"R8 ", 1'b0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210});
    iq.push_back('{"R11", 1'b1, 128'hFFFF_0000_FFFF_0000_1111_2222_3333_4444});
    iq.push_back('{"R8 ", 1'b0, 128'h5A5A_5A5A_5A5A_5A5A_A5A5_A5A5_A5A5_A5A5});
    run_stream(1'b1);

    // R9 preset on an empty marked group, then re-arm
    sq.push_back(mk_hdr(15'd0, 1'b1, 1'b1, 11'h123, 2'd0, 4'd1, 64'h1));
    sq.push_back(mk_hdr(15'd1, 1'b0, 1'b0, 11'h0, 2'd0, 4'd1, 64'h3));
    sq.push_back(128'h0000_0000_0000_0000_0000_0006_0000_0005);
    eq.push_back('{"R9 ", 1'b1, 1'b1, 8'h00, 64'h0000_0000_0000_0123});
    eq.push_back('{"R2 ", 1'b0, 1'b0, 8'h03, 64'h0000_0000_0006_0005});
    run_stream(1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule